// File: doc/BRIEF.md
# Paged Receive Buffer Ring Manager

This block places incoming network frames into a local packet memory that is organised as a ring of fixed-size pages. Software programs a first ring page and a stop page (the ring uses every page from the first up to, but excluding, the stop page). It also supplies a boundary page, which marks the oldest page it has not yet read. A byte stream with start and end markers arrives from the receive MAC. On the last byte, the MAC also gives a verdict saying whether the frame is damaged (runt, CRC or alignment error).

Each frame starts at the page held in the current-page register. The first four bytes of that page are left free. Frame bytes, including the trailing CRC, are written one per beat through a registered byte-wide memory port. When a page is full, the next ring page is linked in, wrapping from the stop page back to the first page. If that next page is the host's boundary page, the frame is aborted and an overwrite warning is raised.

A frame that is kept gets a four-byte header written at the start of its first page, and the current-page register moves to the page after the last page used. A damaged frame is dropped by leaving the current-page register where it was, so every page it touched is reused. Software may ask for damaged frames to be kept instead.

Top module: `rxr_ring_mgr`

## Requirements
- R1: During reset, `mem_we`, `rx_done`, `ovw_flag` and `cur_page` are all 0. A `ring_init` pulse loads `cur_page` from `ring_start` and clears `ovw_flag`.
- R2: The first byte of a frame is written at byte offset 4 of page `cur_page`, where memory address = {page, offset}. Later bytes go to consecutive offsets. Each byte reaches the memory port one cycle after the clock edge that sampled it.
- R3: Once the last offset of a page has been written, the next byte of the frame goes to offset 0 of the following page. Pages are never skipped.
- R4: The page after `ring_stop - 1` is `ring_start`. This applies both when a frame links pages and when the next-frame page is computed.
- R5: A kept frame gets four header writes at offsets 0 to 3 of its first page. They appear on the four cycles after the last data write, in this order: status, next-frame page, byte count bits 7:0, byte count bits 15:8. Status is 8'h01 for an intact frame and 8'h02 for a damaged frame kept in accept-errors mode. The byte count covers every frame byte, CRC included.
- R6: `cur_page` takes the next-frame page two edges after the edge that sampled the last byte. `rx_done` pulses for one cycle together with the final header write.
- R7: The next-frame page is the page after the last page written. Unused bytes at the end of that last page are never written, even when the frame fills the page exactly.
- R8: When `rx_bad` is 1 on the last byte and `accept_err` is 0, the frame gets no header and no `rx_done`, and `cur_page` stays unchanged. The next frame reuses the same first page.
- R9: When `accept_err` is 1, a frame with `rx_bad` set is kept like an intact frame, with status 8'h02.
- R10: If the page to be linked equals `host_bnd`, no further byte of that frame is written. `ovw_flag` is set, no header is written, and `cur_page` is unchanged.
- R11: A start of frame while `cur_page` equals `host_bnd` writes nothing and sets `ovw_flag`.
- R12: While `ovw_flag` is 1, every new frame is refused with no memory write. `ovw_flag` stays set until an `ovw_clr` pulse.
- R13: Beats that arrive outside a frame (no start marker since the last end) write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_init | input | 1 | Load current page from ring start, clear the warning |
| ring_start | input | PAGE_W | First page of the ring |
| ring_stop | input | PAGE_W | Page just past the ring |
| host_bnd | input | PAGE_W | Oldest page not yet read by the host |
| accept_err | input | 1 | Keep damaged frames |
| ovw_clr | input | 1 | Clear the overwrite warning |
| rx_valid | input | 1 | Byte beat present |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_bad | input | 1 | Frame damaged (valid with rx_eof) |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PAGE_W+OFFS_W | Byte address {page, offset} |
| mem_wdata | output | 8 | Byte to write |
| cur_page | output | PAGE_W | First page of the next frame |
| ovw_flag | output | 1 | Overwrite warning |
| rx_done | output | 1 | One-cycle pulse when a frame is committed |

The stream must leave at least four idle beats between a last byte and the next start, so the header writes have the port to themselves. `ring_start`, `ring_stop` and `host_bnd` must not change during a frame.

## Verification
The bench builds the block with 8-bit page numbers and 16-byte pages (OFFS_W=4), and uses a four-page ring from page 2 to page 5. With these values, a page link happens after only 12 frame bytes. A 14-byte frame starting on the last ring page wraps back to the first ring page. A boundary collision can be reached with a 30-byte frame. This makes every linking, wrapping, rejection and overwrite case short enough to be checked byte by byte against a page model held in the bench.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_RECV,
    FS_DROP
  } fill_st_e;

  localparam int          HDR_BYTES     = 4;
  localparam logic [7:0]  STAT_INTACT   = 8'h01;
  localparam logic [7:0]  STAT_KEPT_ERR = 8'h02;

endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] ring_start,
  input  logic [PAGE_W-1:0] ring_stop,
  output logic [PAGE_W-1:0] next_pg
);

  logic [PAGE_W-1:0] inc_pg;

  always_comb begin
    inc_pg = cur_pg + PAGE_W'(1);
    if (inc_pg == ring_stop) begin
      next_pg = ring_start;
    end else begin
      next_pg = inc_pg;
    end
  end

endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ring_init,
  input  logic [PAGE_W-1:0]        ring_start,
  input  logic [PAGE_W-1:0]        ring_stop,
  input  logic [PAGE_W-1:0]        host_bnd,
  input  logic                     accept_err,
  input  logic                     ovw_clr,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_eof,
  input  logic [7:0]               in_data,
  input  logic                     in_bad,
  output logic                     wreq,
  output logic [PAGE_W+OFFS_W-1:0] waddr,
  output logic [7:0]               wdata,
  output logic                     commit,
  output logic [7:0]               commit_stat,
  output logic [CNT_W-1:0]         commit_cnt,
  output logic [PAGE_W-1:0]        cur_page,
  output logic                     ovw
);

  localparam logic [OFFS_W-1:0] HDR_OFF = OFFS_W'(HDR_BYTES);

  fill_st_e          st_q, st_d;
  logic [PAGE_W-1:0] wr_page_q, wr_page_d;
  logic [OFFS_W-1:0] wr_off_q, wr_off_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PAGE_W-1:0] cur_q, cur_d;
  logic              ovw_q, ovw_d;
  logic              commit_q;
  logic [PAGE_W-1:0] scratch_q, scratch_d;
  logic              took;
  logic              dp_en;

  // Following ring page of the page being filled, kept in a scratch register
  rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
    .cur_pg     (wr_page_d),
    .ring_start (ring_start),
    .ring_stop  (ring_stop),
    .next_pg    (scratch_d)
  );

  always_comb begin
    st_d        = st_q;
    wr_page_d   = wr_page_q;
    wr_off_d    = wr_off_q;
    cnt_d       = cnt_q;
    cur_d       = cur_q;
    ovw_d       = ovw_q;
    wreq        = 1'b0;
    waddr       = '0;
    commit      = 1'b0;
    commit_stat = STAT_INTACT;
    took        = 1'b0;

    // Advance the current page one edge after a commit
    if (commit_q) begin
      cur_d = scratch_q;
    end

    if (ovw_clr) begin
      ovw_d = 1'b0;
    end

    if (in_valid) begin
      if (in_sof) begin
        if (ovw_q || (cur_q == host_bnd)) begin
          ovw_d = 1'b1;
          st_d  = in_eof ? FS_IDLE : FS_DROP;
        end else begin
          wreq      = 1'b1;
          waddr     = {cur_q, HDR_OFF};
          wr_page_d = cur_q;
          wr_off_d  = HDR_OFF + OFFS_W'(1);
          cnt_d     = CNT_W'(1);
          took      = 1'b1;
          st_d      = FS_RECV;
        end
      end else if (st_q == FS_RECV) begin
        if (wr_off_q == '0) begin
          // Page exhausted: link the following ring page unless it is the host's
          if (scratch_q == host_bnd) begin
            ovw_d = 1'b1;
            st_d  = in_eof ? FS_IDLE : FS_DROP;
          end else begin
            wreq      = 1'b1;
            waddr     = {scratch_q, {OFFS_W{1'b0}}};
            wr_page_d = scratch_q;
            wr_off_d  = OFFS_W'(1);
            cnt_d     = cnt_q + CNT_W'(1);
            took      = 1'b1;
          end
        end else begin
          wreq     = 1'b1;
          waddr    = {wr_page_q, wr_off_q};
          wr_off_d = wr_off_q + OFFS_W'(1);
          cnt_d    = cnt_q + CNT_W'(1);
          took     = 1'b1;
        end
      end else if ((st_q == FS_DROP) && in_eof) begin
        st_d = FS_IDLE;
      end

      if (took && in_eof) begin
        st_d = FS_IDLE;
        if (!in_bad || accept_err) begin
          commit      = 1'b1;
          commit_stat = in_bad ? STAT_KEPT_ERR : STAT_INTACT;
        end
      end
    end

    if (ring_init) begin
      cur_d = ring_start;
      ovw_d = 1'b0;
      st_d  = FS_IDLE;
    end
  end

  assign dp_en       = in_valid;
  assign wdata       = in_data;
  assign commit_cnt  = cnt_d;
  assign cur_page    = cur_q;
  assign ovw         = ovw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FS_IDLE;
      cur_q     <= '0;
      ovw_q     <= 1'b0;
      commit_q  <= 1'b0;
      scratch_q <= '0;
    end else begin
      st_q      <= st_d;
      cur_q     <= cur_d;
      ovw_q     <= ovw_d;
      commit_q  <= commit;
      scratch_q <= scratch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_page_q <= '0;
      wr_off_q  <= '0;
      cnt_q     <= '0;
    end else if (dp_en) begin
      wr_page_q <= wr_page_d;
      wr_off_q  <= wr_off_d;
      cnt_q     <= cnt_d;
    end
  end

endmodule

// File: rtl/rxr_hdr_seq.sv
module rxr_hdr_seq #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [PAGE_W-1:0]        ld_page,
  input  logic [7:0]               ld_stat,
  input  logic [CNT_W-1:0]         ld_cnt,
  input  logic [PAGE_W-1:0]        next_page,
  output logic                     hw_we,
  output logic [PAGE_W+OFFS_W-1:0] hw_addr,
  output logic [7:0]               hw_data,
  output logic                     hw_last
);

  logic              busy_q, busy_d;
  logic [1:0]        idx_q, idx_d;
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        stat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [15:0]       cnt16;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      idx_d = idx_q + 2'd1;
      if (idx_q == 2'd3) begin
        busy_d = 1'b0;
      end
    end
    if (load) begin
      busy_d = 1'b1;
      idx_d  = 2'd0;
    end
  end

  assign cnt16 = 16'(cnt_q);

  always_comb begin
    unique case (idx_q)
      2'd0:    hw_data = stat_q;
      2'd1:    hw_data = 8'(next_page);
      2'd2:    hw_data = cnt16[7:0];
      default: hw_data = cnt16[15:8];
    endcase
  end

  assign hw_we   = busy_q;
  assign hw_addr = {page_q, OFFS_W'(idx_q)};
  assign hw_last = busy_q && (idx_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      page_q <= ld_page;
      stat_q <= ld_stat;
      cnt_q  <= ld_cnt;
    end
  end

endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ring_init,
  input  logic [PAGE_W-1:0]        ring_start,
  input  logic [PAGE_W-1:0]        ring_stop,
  input  logic [PAGE_W-1:0]        host_bnd,
  input  logic                     accept_err,
  input  logic                     ovw_clr,
  input  logic                     rx_valid,
  input  logic                     rx_sof,
  input  logic                     rx_eof,
  input  logic [7:0]               rx_data,
  input  logic                     rx_bad,
  output logic                     mem_we,
  output logic [PAGE_W+OFFS_W-1:0] mem_addr,
  output logic [7:0]               mem_wdata,
  output logic [PAGE_W-1:0]        cur_page,
  output logic                     ovw_flag,
  output logic                     rx_done
);

  localparam int AW = PAGE_W + OFFS_W;

  logic              fill_wreq;
  logic [AW-1:0]     fill_addr;
  logic [7:0]        fill_data;
  logic              commit;
  logic [7:0]        commit_stat;
  logic [CNT_W-1:0]  commit_cnt;
  logic              hdr_we;
  logic [AW-1:0]     hdr_addr;
  logic [7:0]        hdr_data;
  logic              hdr_last;

  logic              we_d, we_q;
  logic [AW-1:0]     addr_d, addr_q;
  logic [7:0]        data_d, data_q;
  logic              done_q;

  rxr_fill #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .CNT_W(CNT_W)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_init   (ring_init),
    .ring_start  (ring_start),
    .ring_stop   (ring_stop),
    .host_bnd    (host_bnd),
    .accept_err  (accept_err),
    .ovw_clr     (ovw_clr),
    .in_valid    (rx_valid),
    .in_sof      (rx_sof),
    .in_eof      (rx_eof),
    .in_data     (rx_data),
    .in_bad      (rx_bad),
    .wreq        (fill_wreq),
    .waddr       (fill_addr),
    .wdata       (fill_data),
    .commit      (commit),
    .commit_stat (commit_stat),
    .commit_cnt  (commit_cnt),
    .cur_page    (cur_page),
    .ovw         (ovw_flag)
  );

  rxr_hdr_seq #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .CNT_W(CNT_W)) u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (commit),
    .ld_page   (cur_page),
    .ld_stat   (commit_stat),
    .ld_cnt    (commit_cnt),
    .next_page (cur_page),
    .hw_we     (hdr_we),
    .hw_addr   (hdr_addr),
    .hw_data   (hdr_data),
    .hw_last   (hdr_last)
  );

  // Memory port arbitration: frame bytes first, header bytes in the gap
  always_comb begin
    we_d   = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (fill_wreq) begin
      we_d   = 1'b1;
      addr_d = fill_addr;
      data_d = fill_data;
    end else if (hdr_we) begin
      we_d   = 1'b1;
      addr_d = hdr_addr;
      data_d = hdr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      we_q   <= we_d;
      done_q <= hdr_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (we_d) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign rx_done   = done_q;

endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ring_init,
  input logic                     ovw_clr,
  input logic [PAGE_W-1:0]        host_bnd,
  input logic                     rx_valid,
  input logic                     rx_sof,
  input logic                     mem_we,
  input logic [PAGE_W+OFFS_W-1:0] mem_addr,
  input logic [PAGE_W-1:0]        cur_page,
  input logic                     ovw_flag,
  input logic                     rx_done,
  input logic                     fill_wreq,
  input logic                     hdr_we
);

  localparam int OW = OFFS_W;

  // R2: an accepted start lands at offset 4 of the current page one cycle later
  a_r2_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && !ovw_flag && (cur_page != host_bnd))
    |=> (mem_we && (mem_addr == {$past(cur_page), OW'(4)})));

  // R5: frame bytes and header bytes never compete for the port
  a_r5_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wreq |-> !hdr_we);

  // R6: the done pulse accompanies the last header byte (offset 3)
  a_r6_done_with_last_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (mem_we && (mem_addr[OW-1:0] == OW'(3))));

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R12: the warning holds until cleared
  a_r12_ovw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovw_flag && !ovw_clr && !ring_init) |=> ovw_flag);

  // R12: a start while the warning is up produces no write
  a_r12_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (ovw_flag && rx_valid && rx_sof) |=> !mem_we);

endmodule

bind rxr_ring_mgr rxr_ring_chk #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ring_init (ring_init),
  .ovw_clr   (ovw_clr),
  .host_bnd  (host_bnd),
  .rx_valid  (rx_valid),
  .rx_sof    (rx_sof),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .cur_page  (cur_page),
  .ovw_flag  (ovw_flag),
  .rx_done   (rx_done),
  .fill_wreq (fill_wreq),
  .hdr_we    (hdr_we)
);

// File: tb/test_rxr_ring_mgr.sv
`timescale 1ns/1ps
module test_rxr_ring_mgr;

  localparam int PW = 8;
  localparam int OW = 4;
  localparam int AW = PW + OW;
  localparam int PG = 16;
  localparam logic [7:0] RSTART = 8'd2;
  localparam logic [7:0] RSTOP  = 8'd6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, ring_init, accept_err, ovw_clr;
  logic [PW-1:0] ring_start, ring_stop, host_bnd;
  logic          rx_valid, rx_sof, rx_eof, rx_bad;
  logic [7:0]    rx_data;
  logic          mem_we, ovw_flag, rx_done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [PW-1:0] cur_page;

  rxr_ring_mgr #(.PAGE_W(PW), .OFFS_W(OW), .CNT_W(16)) i_rxr_ring_mgr (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .ring_start(ring_start),
    .ring_stop(ring_stop), .host_bnd(host_bnd), .accept_err(accept_err),
    .ovw_clr(ovw_clr), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_bad(rx_bad), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_page(cur_page), .ovw_flag(ovw_flag), .rx_done(rx_done)
  );

  logic [7:0] mem [0:(1<<AW)-1];
  int wr_cnt = 0;
  int done_cnt = 0;
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (rx_done) done_cnt <= done_cnt + 1;
  end

  int checks = 0;
  int errors = 0;
  int fr_wr, fr_done;
  logic [7:0] post_cur [0:5];
  logic       post_done [0:5];
  logic [7:0] exp_cur;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt_pg(input logic [7:0] p);
    return ((p + 8'd1) == RSTOP) ? RSTART : (p + 8'd1);
  endfunction

  task automatic send_frame(input int len, input logic bad, input logic [7:0] base);
    int w0, d0;
    w0 = wr_cnt;
    d0 = done_cnt;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = base + 8'(i);
      rx_bad   = bad && (i == len - 1);
    end
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_bad = 1'b0;
      post_cur[j]  = cur_page;
      post_done[j] = rx_done;
    end
    @(negedge clk);
    fr_wr   = wr_cnt - w0;
    fr_done = done_cnt - d0;
  endtask

  // Checks a kept frame against the page model, then advances the model
  task automatic check_frame(input string tag, input int len, input logic [7:0] base,
                             input logic [7:0] stat);
    logic [7:0] p, nextp;
    int off, bad_n;
    p = exp_cur; off = 4; bad_n = 0;
    for (int i = 0; i < len; i++) begin
      if (off == PG) begin p = nxt_pg(p); off = 0; end
      if (mem[{p, 4'(off)}] !== base + 8'(i)) bad_n++;
      off++;
    end
    nextp = nxt_pg(p);
    chk({tag, " R2 R3 R4 data bytes mismatching"}, bad_n, 0);
    chk({tag, " R5 header status"}, mem[{exp_cur, 4'd0}], stat);
    chk({tag, " R5 R7 header next page"}, mem[{exp_cur, 4'd1}], nextp);
    chk({tag, " R5 header count low"}, mem[{exp_cur, 4'd2}], len & 8'hff);
    chk({tag, " R5 header count high"}, mem[{exp_cur, 4'd3}], (len >> 8) & 8'hff);
    chk({tag, " R7 write count"}, fr_wr, len + 4);
    chk({tag, " R6 done pulses"}, fr_done, 1);
    chk({tag, " R6 cur_page"}, cur_page, nextp);
    exp_cur = nextp;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ring_init = 0; accept_err = 0; ovw_clr = 0;
    ring_start = RSTART; ring_stop = RSTOP; host_bnd = 8'd1;
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_bad = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset mem_we", mem_we, 0);
    chk("R1 reset cur_page", cur_page, 0);
    chk("R1 reset ovw_flag", ovw_flag, 0);
    chk("R1 reset rx_done", rx_done, 0);
    rst_n = 1'b1;
    @(negedge clk); ring_init = 1'b1;
    @(negedge clk); ring_init = 1'b0;
    chk("R1 ring_init loads cur_page", cur_page, RSTART);
    exp_cur = RSTART;
  endtask

  task automatic t_short_timing;
    send_frame(5, 1'b0, 8'h10);
    chk("R6 cur_page one edge after last byte", post_cur[0], 8'd2);
    chk("R6 cur_page two edges after last byte", post_cur[1], 8'd3);
    chk("R6 done not early", post_done[3], 0);
    chk("R6 done with last header", post_done[4], 1);
    chk("R6 done one cycle", post_done[5], 0);
    check_frame("short", 5, 8'h10, 8'h01);
  endtask

  task automatic t_link;
    send_frame(20, 1'b0, 8'h40);
    check_frame("R3 two pages", 20, 8'h40, 8'h01);
  endtask

  task automatic t_wrap;
    send_frame(14, 1'b0, 8'h80);
    chk("R4 wrapped byte at ring start", mem[{RSTART, 4'd0}], 8'h80 + 8'd12);
    check_frame("R4 wrap", 14, 8'h80, 8'h01);
  endtask

  task automatic t_exact;
    send_frame(12, 1'b0, 8'hA0);
    check_frame("R7 exact fill", 12, 8'hA0, 8'h01);
  endtask

  task automatic t_reject;
    logic [7:0] keep;
    keep = exp_cur;
    send_frame(18, 1'b1, 8'h20);
    chk("R8 no done on reject", fr_done, 0);
    chk("R8 only data written", fr_wr, 18);
    chk("R8 cur_page unchanged", cur_page, keep);
    send_frame(3, 1'b0, 8'h60);
    chk("R8 page reused", mem[{keep, 4'd4}], 8'h60);
    check_frame("R8 after reject", 3, 8'h60, 8'h01);
  endtask

  task automatic t_accept;
    accept_err = 1'b1;
    send_frame(4, 1'b1, 8'h30);
    check_frame("R9 kept damaged", 4, 8'h30, 8'h02);
    accept_err = 1'b0;
  endtask

  task automatic t_bnd_link;
    host_bnd = 8'd3;
    send_frame(30, 1'b0, 8'h50);
    chk("R10 writes stop at boundary", fr_wr, 12);
    chk("R10 no done", fr_done, 0);
    chk("R10 ovw set", ovw_flag, 1);
    chk("R10 cur_page unchanged", cur_page, exp_cur);
  endtask

  task automatic t_refuse;
    send_frame(3, 1'b0, 8'h70);
    chk("R12 refused frame writes", fr_wr, 0);
    chk("R12 ovw held", ovw_flag, 1);
    @(negedge clk); ovw_clr = 1'b1;
    @(negedge clk); ovw_clr = 1'b0;
    chk("R12 ovw cleared", ovw_flag, 0);
    send_frame(3, 1'b0, 8'h74);
    check_frame("R12 after clear", 3, 8'h74, 8'h01);
  endtask

  task automatic t_start_bnd;
    send_frame(3, 1'b0, 8'h90);
    chk("R11 no write at boundary start", fr_wr, 0);
    chk("R11 ovw set", ovw_flag, 1);
    @(negedge clk); ovw_clr = 1'b1; host_bnd = 8'd2;
    @(negedge clk); ovw_clr = 1'b0;
    send_frame(3, 1'b0, 8'h94);
    check_frame("R11 after host read", 3, 8'h94, 8'h01);
  endtask

  task automatic t_stray;
    int w0;
    w0 = wr_cnt;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 2); rx_data = 8'hEE;
    end
    repeat (6) @(negedge clk) rx_valid = 1'b0;
    chk("R13 stray beats write nothing", wr_cnt - w0, 0);
    chk("R13 cur_page unchanged", cur_page, exp_cur);
  endtask

  task automatic t_single;
    send_frame(1, 1'b0, 8'hC5);
    check_frame("R2 single byte", 1, 8'hC5, 8'h01);
  endtask

  initial begin
    t_reset();
    t_short_timing();
    t_link();
    t_wrap();
    t_exact();
    t_reject();
    t_accept();
    t_bnd_link();
    t_refuse();
    t_start_bnd();
    t_stray();
    t_single();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule